// File: doc/BRIEF.md
# Resistive Touch X/Y/Z Sampler

This block performs one complete X, Y and Z measurement on a resistive-touch converter that shares its serial bus with a display. An external bus arbiter hands the bus over with a one-cycle `grant` pulse. The sampler pulls the touch chip-select low and clocks out a fixed 51-bit command stream built from three loadable command bytes. At the same time it captures the converter's reply stream. It then releases chip-select and reports completion to the arbiter with a one-cycle `done` pulse. In that same cycle the three 12-bit results appear together with a one-cycle `res_valid` strobe.

No sample is counted out bit by bit. The outgoing stream is held as three 17-bit slices that are shifted out back to back. The incoming stream is cut into 15-bit frames whose fill counter starts at 9 instead of 0. With that offset the three replies land in fixed positions of frames one to three, and frame zero is thrown away. The serial clock is a divided system clock, and elaboration rejects any divider that would exceed 2.5 MHz.

Top module: `touch_xyz_sampler`

## Requirements
- R1: A `grant` pulse seen while idle starts one acquisition. `tp_cs_n` goes low and exactly 51 rising `tp_sclk` edges follow. `tp_sclk` stays low whenever `tp_cs_n` is high.
- R2: Number the serial bit positions 0 to 50 in transmit order. Command k (0=X from `cmd_x`, 1=Y from `cmd_y`, 2=Z from `cmd_z`) is sent MSB first at positions 15k to 15k+7. Every other position carries 0.
- R3: `tp_mosi` changes only when `tp_sclk` falls or at the start of an acquisition, never while `tp_sclk` is high. `tp_miso` is sampled on each rising `tp_sclk` edge.
- R4: Number the `tp_miso` bits sampled on the rising edges 0 to 50. Result k is the 12 bits at positions 15k+9 to 15k+20, MSB first, with X for k=0, Y for k=1 and Z for k=2. All other received bits have no effect on any result.
- R5: Each `tp_sclk` half period lasts `HALF_DIV` system clocks. Elaboration fails if `SYS_CLK_HZ/(2*HALF_DIV)` exceeds 2.5 MHz.
- R6: `tp_cs_n` returns high at least one system clock before `done`. `done` is a single-cycle pulse.
- R7: `res_valid` is high for exactly one cycle, in the same cycle as `done`. `res_x`, `res_y` and `res_z` change only in that cycle and hold their values otherwise.
- R8: A `grant` that arrives while an acquisition is in progress is ignored, including in its final cycle. A `grant` arriving in the cycle `done` is high starts the next acquisition.
- R9: After reset `tp_cs_n`=1, `tp_sclk`=0, `tp_mosi`=0, `done`=0, `res_valid`=0, and all results are 0.
- R10: The command bytes are taken when the acquisition starts. Changing them during an acquisition does not alter the transmitted stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | One-cycle bus hand-over from the arbiter |
| cmd_x | input | CMD_W | Command byte for the X measurement |
| cmd_y | input | CMD_W | Command byte for the Y measurement |
| cmd_z | input | CMD_W | Command byte for the Z measurement |
| done | output | 1 | One-cycle bus return to the arbiter |
| tp_cs_n | output | 1 | Touch converter chip-select, active low |
| tp_sclk | output | 1 | Touch serial clock, idles low |
| tp_mosi | output | 1 | Serial command data to the converter |
| tp_miso | input | 1 | Serial reply data from the converter |
| res_x | output | SAMPLE_W | X result |
| res_y | output | SAMPLE_W | Y result |
| res_z | output | SAMPLE_W | Z result |
| res_valid | output | 1 | One-cycle strobe when the results update |

## Verification
The completion cycle is also a cycle in which a new `grant` can arrive, so bus return and bus hand-over may collide. The bench raises `grant` in the cycle just after it sees chip-select rise, which is the last cycle before idle. It then watches `tp_cs_n` for several half periods and expects it to stay high. In other runs it raises `grant` in the cycle in which `done` is high and expects a new acquisition whose command stream and results match the values it computes from the bit-position rules.

// File: rtl/touch_samp_pkg.sv
package touch_samp_pkg;

   typedef enum logic [1:0] {
      TS_IDLE,
      TS_RUN,
      TS_TAIL,
      TS_FIN
   } ts_state_e;

endpackage

// File: rtl/tsamp_tick_gen.sv
module tsamp_tick_gen #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(HALF_DIV + 1);

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!en)      cnt <= '0;
      else if (tick)     cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tsamp_cmd_serializer.sv
module tsamp_cmd_serializer #(
   parameter int SLICE_W = 17,
   parameter int N_SLICE = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic                       advance,
   input  logic [N_SLICE*SLICE_W-1:0] slices,
   output logic                       bit_out
);
   localparam int PW = $clog2(SLICE_W);

   logic [SLICE_W-1:0] cur;
   logic [SLICE_W-1:0] pend [N_SLICE-1];
   logic [PW-1:0]      pos;

   assign bit_out = cur[SLICE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         pos <= '0;
         for (int i = 0; i < N_SLICE - 1; i++) pend[i] <= '0;
      end else if (load) begin
         cur <= slices[0 +: SLICE_W];
         pos <= '0;
         for (int i = 0; i < N_SLICE - 1; i++) pend[i] <= slices[(i+1)*SLICE_W +: SLICE_W];
      end else if (advance) begin
         if (pos == PW'(SLICE_W - 1)) begin
            cur <= pend[0];
            pos <= '0;
            for (int i = 0; i < N_SLICE - 2; i++) pend[i] <= pend[i+1];
            pend[N_SLICE-2] <= '0;
         end else begin
            cur <= {cur[SLICE_W-2:0], 1'b0};
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tsamp_reply_framer.sv
module tsamp_reply_framer #(
   parameter int FRAME_W  = 15,
   parameter int PRELOAD  = 9,
   parameter int SAMPLE_W = 12,
   parameter int N_CH     = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       bit_valid,
   input  logic                       bit_in,
   output logic [N_CH*SAMPLE_W-1:0]   samples
);
   localparam int FW = $clog2(FRAME_W);
   localparam int WW = $clog2(N_CH + 2);

   logic [SAMPLE_W-2:0] isr;
   logic [SAMPLE_W-1:0] nxt;
   logic [FW-1:0]       fill;
   logic [WW-1:0]       widx;
   logic                push;

   assign nxt  = {isr, bit_in};
   assign push = bit_valid && (fill == FW'(FRAME_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr  <= '0;
         fill <= '0;
         widx <= '0;
      end else if (start) begin
         isr  <= '0;
         fill <= FW'(PRELOAD);
         widx <= '0;
      end else if (push) begin
         isr  <= '0;
         fill <= '0;
         widx <= widx + 1'b1;
      end else if (bit_valid) begin
         isr  <= nxt[SAMPLE_W-2:0];
         fill <= fill + 1'b1;
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_slot
      logic [SAMPLE_W-1:0] slot;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               slot <= '0;
         else if (push && widx == WW'(c + 1))      slot <= nxt;
      end
      assign samples[c*SAMPLE_W +: SAMPLE_W] = slot;
   end
endmodule

// File: rtl/touch_xyz_sampler.sv
module touch_xyz_sampler
   import touch_samp_pkg::*;
#(
   parameter int SYS_CLK_HZ  = 50_000_000,
   parameter int MAX_SCLK_HZ = 2_500_000,
   parameter int HALF_DIV    = 10,
   parameter int CMD_W       = 8,
   parameter int SAMPLE_W    = 12,
   parameter int FRAME_W     = 15,
   parameter int REPLY_DELAY = 9,
   parameter bit MISO_SYNC   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                grant,
   input  logic [CMD_W-1:0]    cmd_x,
   input  logic [CMD_W-1:0]    cmd_y,
   input  logic [CMD_W-1:0]    cmd_z,
   output logic                done,
   output logic                tp_cs_n,
   output logic                tp_sclk,
   output logic                tp_mosi,
   input  logic                tp_miso,
   output logic [SAMPLE_W-1:0] res_x,
   output logic [SAMPLE_W-1:0] res_y,
   output logic [SAMPLE_W-1:0] res_z,
   output logic                res_valid
);
   localparam int N_CH     = 3;
   localparam int STREAM_W = (N_CH - 1) * FRAME_W + REPLY_DELAY + SAMPLE_W;
   localparam int SLICE_W  = STREAM_W / N_CH;
   localparam int PRELOAD  = 2 * FRAME_W - REPLY_DELAY - SAMPLE_W;
   localparam int IW       = $clog2(STREAM_W);

   // elaboration-time parameter checks
   if (SYS_CLK_HZ / (2 * HALF_DIV) > MAX_SCLK_HZ) begin : g_err_rate
      $error("touch serial clock above its limit");
   end
   if (HALF_DIV < (MISO_SYNC ? 3 : 1)) begin : g_err_div
      $error("half period too short for the input path");
   end
   if (SLICE_W * N_CH != STREAM_W) begin : g_err_slice
      $error("stream does not split into equal slices");
   end
   if (PRELOAD < 0 || PRELOAD >= FRAME_W || CMD_W > FRAME_W || SAMPLE_W > FRAME_W) begin : g_err_frame
      $error("frame geometry inconsistent");
   end

   ts_state_e   state;
   logic [IW-1:0] bit_idx;
   logic        tick, load, advance, sample, last_bit, miso_s, ser_bit;
   logic [CMD_W-1:0]            cmd_arr [N_CH];
   logic [STREAM_W-1:0]         stream;
   logic [STREAM_W-1:0]         slices;
   logic [N_CH*SAMPLE_W-1:0]    samples;

   assign cmd_arr[0] = cmd_x;
   assign cmd_arr[1] = cmd_y;
   assign cmd_arr[2] = cmd_z;

   // command bitstream: byte k at positions k*FRAME_W .. k*FRAME_W+CMD_W-1
   for (genvar gi = 0; gi < STREAM_W; gi++) begin : g_stream
      if ((gi / FRAME_W) < N_CH && (gi % FRAME_W) < CMD_W) begin : g_cmd
         assign stream[gi] = cmd_arr[gi / FRAME_W][CMD_W - 1 - (gi % FRAME_W)];
      end else begin : g_zero
         assign stream[gi] = 1'b0;
      end
   end

   // slice s is sent from its MSB
   for (genvar s = 0; s < N_CH; s++) begin : g_slice
      for (genvar j = 0; j < SLICE_W; j++) begin : g_pos
         assign slices[s*SLICE_W + (SLICE_W - 1 - j)] = stream[s*SLICE_W + j];
      end
   end

   if (MISO_SYNC) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], tp_miso};
      end
      assign miso_s = sync_q[1];
   end else begin : g_direct
      assign miso_s = tp_miso;
   end

   assign last_bit = (bit_idx == IW'(STREAM_W - 1));
   assign load     = (state == TS_IDLE) && grant;
   assign sample   = (state == TS_RUN) && tick && !tp_sclk;
   assign advance  = (state == TS_RUN) && tick && tp_sclk && !last_bit;
   assign tp_mosi  = ser_bit & ~tp_cs_n;

   tsamp_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (state == TS_RUN || state == TS_TAIL),
      .tick (tick)
   );

   tsamp_cmd_serializer #(.SLICE_W(SLICE_W), .N_SLICE(N_CH)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .advance(advance),
      .slices (slices),
      .bit_out(ser_bit)
   );

   tsamp_reply_framer #(
      .FRAME_W(FRAME_W), .PRELOAD(PRELOAD), .SAMPLE_W(SAMPLE_W), .N_CH(N_CH)
   ) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (load),
      .bit_valid(sample),
      .bit_in   (miso_s),
      .samples  (samples)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TS_IDLE;
         tp_cs_n   <= 1'b1;
         tp_sclk   <= 1'b0;
         bit_idx   <= '0;
         done      <= 1'b0;
         res_valid <= 1'b0;
         res_x     <= '0;
         res_y     <= '0;
         res_z     <= '0;
      end else begin
         done      <= 1'b0;
         res_valid <= 1'b0;
         unique case (state)
            TS_IDLE: if (grant) begin
               state   <= TS_RUN;
               tp_cs_n <= 1'b0;
               tp_sclk <= 1'b0;
               bit_idx <= '0;
            end
            TS_RUN: if (tick) begin
               if (!tp_sclk) tp_sclk <= 1'b1;
               else begin
                  tp_sclk <= 1'b0;
                  if (last_bit) state <= TS_TAIL;
                  else          bit_idx <= bit_idx + 1'b1;
               end
            end
            TS_TAIL: if (tick) begin
               tp_cs_n <= 1'b1;
               state   <= TS_FIN;
            end
            TS_FIN: begin
               done      <= 1'b1;
               res_valid <= 1'b1;
               res_x     <= samples[0*SAMPLE_W +: SAMPLE_W];
               res_y     <= samples[1*SAMPLE_W +: SAMPLE_W];
               res_z     <= samples[2*SAMPLE_W +: SAMPLE_W];
               state     <= TS_IDLE;
            end
            default: state <= TS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/touch_xyz_sampler_chk.sv
module touch_xyz_sampler_chk #(
   parameter int SAMPLE_W = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                grant,
   input logic                done,
   input logic                tp_cs_n,
   input logic                tp_sclk,
   input logic                tp_mosi,
   input logic [SAMPLE_W-1:0] res_x,
   input logic [SAMPLE_W-1:0] res_y,
   input logic [SAMPLE_W-1:0] res_z,
   input logic                res_valid
);
   assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tp_cs_n |-> !tp_sclk);

   assert_start_on_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tp_cs_n) |-> $past(grant));

   assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tp_sclk && $past(tp_sclk)) |-> $stable(tp_mosi));

   assert_cs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tp_cs_n && $past(tp_cs_n)));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> done);

   assert_done_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> res_valid);

   assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable({res_x, res_y, res_z}));
endmodule

bind touch_xyz_sampler touch_xyz_sampler_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grant    (grant),
   .done     (done),
   .tp_cs_n  (tp_cs_n),
   .tp_sclk  (tp_sclk),
   .tp_mosi  (tp_mosi),
   .res_x    (res_x),
   .res_y    (res_y),
   .res_z    (res_z),
   .res_valid(res_valid)
);

// File: tb/touch_xyz_sampler_test.sv
`timescale 1ns/1ps
module touch_xyz_sampler_test;
   localparam int HD = 10;
   localparam int NB = 51;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        grant = 1'b0;
   logic [7:0]  cmd_x = '0, cmd_y = '0, cmd_z = '0;
   logic        done, tp_cs_n, tp_sclk, tp_mosi, res_valid;
   logic        tp_miso = 1'b0;
   logic [11:0] res_x, res_y, res_z;

   int n_chk = 0;
   int n_bad = 0;

   logic [NB-1:0] resp;
   logic [NB-1:0] mosi_cap;
   int            n_rise;
   int            m_idx;
   int            per_bad;
   realtime       last_rise;

   always #10 clk = ~clk;

   touch_xyz_sampler #(.HALF_DIV(HD)) uut (
      .clk(clk), .rst_n(rst_n), .grant(grant),
      .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_z(cmd_z),
      .done(done), .tp_cs_n(tp_cs_n), .tp_sclk(tp_sclk), .tp_mosi(tp_mosi),
      .tp_miso(tp_miso), .res_x(res_x), .res_y(res_y), .res_z(res_z),
      .res_valid(res_valid)
   );

   // converter model: reply bit advances on each falling serial clock
   always @(negedge tp_cs_n) begin
      m_idx   = 0;
      tp_miso = resp[0];
      n_rise  = 0;
      per_bad = 0;
   end
   always @(negedge tp_sclk) begin
      if (tp_cs_n === 1'b0) begin
         m_idx = m_idx + 1;
         if (m_idx < NB) tp_miso = resp[m_idx];
      end
   end
   always @(posedge tp_sclk) begin
      if (n_rise < NB) mosi_cap[n_rise] = tp_mosi;
      if (n_rise > 0 && ($realtime - last_rise) != 2.0 * HD * 20.0) per_bad = per_bad + 1;
      last_rise = $realtime;
      n_rise = n_rise + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NB-1:0] exp_stream(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
      logic [NB-1:0] v = '0;
      logic [7:0] cm [3];
      cm[0] = a; cm[1] = b; cm[2] = c;
      for (int i = 0; i < NB; i++) begin
         if (i / 15 < 3 && i % 15 < 8) v[i] = cm[i/15][7 - (i % 15)];
      end
      return v;
   endfunction

   function automatic logic [NB-1:0] build_resp(input logic [11:0] sx, input logic [11:0] sy,
                                                input logic [11:0] sz, input int seed);
      logic [NB-1:0] r;
      logic [11:0] s [3];
      s[0] = sx; s[1] = sy; s[2] = sz;
      for (int i = 0; i < NB; i++) r[i] = ((i * 5 + seed) % 3 == 0);
      for (int k = 0; k < 3; k++)
         for (int j = 0; j < 12; j++) r[15*k + 9 + j] = s[k][11 - j];
      return r;
   endfunction

   // mode 0 plain, 1 grant mid-run, 2 commands change mid-run, 3 grant in final cycle
   task automatic acquire(input logic [7:0] cx, input logic [7:0] cy, input logic [7:0] cz,
                          input logic [11:0] sx, input logic [11:0] sy, input logic [11:0] sz,
                          input int seed, input int mode);
      logic [NB-1:0] expm;
      int  cyc;
      bit  got;
      logic prev_cs;
      cmd_x = cx; cmd_y = cy; cmd_z = cz;
      resp  = build_resp(sx, sy, sz, seed);
      expm  = exp_stream(cx, cy, cz);
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      cyc = 0; got = 0; prev_cs = tp_cs_n;
      while (!got) begin
         @(negedge clk);
         cyc++;
         grant = 1'b0;
         if (mode == 1 && cyc == 300) grant = 1'b1;
         if (mode == 2 && cyc == 200) begin cmd_x = ~cx; cmd_y = ~cy; cmd_z = ~cz; end
         if (done) begin
            got = 1;
            chk(tp_cs_n && prev_cs, "R6 cs high before done", {62'd0, prev_cs, tp_cs_n}, 64'h3);
            chk(n_rise == NB, mode == 1 ? "R8 busy grant ignored" : "R1 rising edge count", n_rise, NB);
            chk(mosi_cap == expm, mode == 2 ? "R10 stream unchanged" : "R2 command stream", mosi_cap, expm);
            chk(res_x == sx, "R4 X result", res_x, sx);
            chk(res_y == sy, "R4 Y result", res_y, sy);
            chk(res_z == sz, "R4 Z result", res_z, sz);
            chk(res_valid == 1'b1, "R7 valid with done", res_valid, 1);
            chk(per_bad == 0, "R5 serial clock period", per_bad, 0);
         end else if (res_valid) begin
            chk(0, "R7 valid without done", res_valid, 0);
         end
         if (mode == 3 && tp_cs_n && !prev_cs) grant = 1'b1;
         prev_cs = tp_cs_n;
      end
      if (mode == 3) begin
         bit stayed = 1;
         for (int i = 0; i < 3 * HD; i++) begin
            @(negedge clk);
            if (!tp_cs_n) stayed = 0;
         end
         chk(stayed, "R8 grant in final cycle ignored", stayed, 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=complete");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(tp_cs_n == 1'b1, "R9 cs after reset", tp_cs_n, 1);
      chk(tp_sclk == 1'b0, "R9 sclk after reset", tp_sclk, 0);
      chk(tp_mosi == 1'b0, "R9 mosi after reset", tp_mosi, 0);
      chk(done == 1'b0 && res_valid == 1'b0, "R9 strobes after reset", {done, res_valid}, 0);
      chk({res_x, res_y, res_z} == 36'd0, "R9 results after reset", {res_x, res_y, res_z}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // sweep a single set bit (and its complement) over every result position
      for (int ch = 0; ch < 3; ch++) begin
         for (int b = 0; b < 12; b++) begin
            logic [11:0] one = 12'(1 << b);
            acquire(8'h93 ^ 8'(b), 8'hD1 ^ 8'(ch), 8'hB5 + 8'(b * 3),
                    ch == 0 ? one : ~one, ch == 1 ? one : ~one, ch == 2 ? one : ~one,
                    ch * 12 + b, 0);
         end
      end

      // all-zero and all-one replies with inverted junk in ignored positions
      acquire(8'h00, 8'hFF, 8'h5A, 12'h000, 12'hFFF, 12'h000, 1, 0);
      acquire(8'hFF, 8'h00, 8'hA5, 12'hFFF, 12'h000, 12'hFFF, 2, 0);

      // grant pulse mid-acquisition (R8)
      acquire(8'hC3, 8'h3C, 8'h81, 12'h123, 12'h456, 12'h789, 4, 1);
      // command bytes change mid-acquisition (R10)
      acquire(8'h87, 8'h97, 8'hA7, 12'hABC, 12'hDEF, 12'h012, 5, 2);
      // grant lands in final cycle, then back-to-back start in the done cycle (R8)
      acquire(8'h11, 8'h22, 8'h44, 12'h800, 12'h001, 12'h7FE, 6, 3);
      acquire(8'hE1, 8'hE2, 8'hE4, 12'h5A5, 12'hA5A, 12'h3C3, 7, 0);
      acquire(8'h0F, 8'hF0, 8'h66, 12'hC0F, 12'h0F0, 12'h999, 8, 0);

      // results hold while idle even with activity on the reply line (R7)
      begin
         bit held = 1;
         for (int i = 0; i < 40; i++) begin
            tp_miso = i[0];
            @(negedge clk);
            if (res_valid || res_x != 12'hC0F || res_y != 12'h0F0 || res_z != 12'h999) held = 0;
         end
         chk(held, "R7 results hold while idle", held, 1);
         chk(tp_cs_n && !tp_sclk, "R1 bus idle after acquisition", {tp_cs_n, tp_sclk}, 2'b10);
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule